// File: doc/BRIEF.md
# Banked Video Memory Window Mapper

This block sits between the host memory decoder and the video memory controller. It converts a host byte address that hits the legacy video aperture into a linear byte address in video memory. A two-bit map mode selects how the aperture is placed. Mode 0 is a 128 KiB window based at 0xA0000. Mode 1 is a 64 KiB window at 0xA0000 that can be moved across all of video memory by a bank register. Mode 2 is a window based at 0xB0000. Mode 3 is not decoded by this block.

Software programs a bank number. The block masks that number to the banks that exist and turns it into a signed 32-bit offset, which is added to the raw host address in mode 1. When the extended display mode is switched off, the offset returns to its default, so that bank 0 maps 0xA0000 to linear address 0. Translation is combinational. The result is registered once, together with a hit flag and a flag that tells the read path to return 0xFF instead of memory data.

Top module: `vram_window_map`

## Requirements
- R1: After reset the stored bank number is 0, the offset is -0xA0000 (0xFFF60000), and the outputs `out_valid`, `out_hit`, `out_rd_ff` and `out_addr` are all 0.
- R2: In map mode 0 (`map_mode` = 0) a request hits, and `out_addr` = host address - 0xA0000.
- R3: In map mode 2 (`map_mode` = 2) a request hits, and `out_addr` = host address - 0xB0000.
- R4: In map mode 1 (`map_mode` = 1) a host address below 0xB0000 hits, and `out_addr` = host address + offset, modulo 2^32. An address below 0xA0000 therefore wraps and is not rejected.
- R5: In map mode 1 a host address at or above 0xB0000 misses, and `out_addr` is 0. A read there sets `out_rd_ff` (the data returned is 0xFF). A write there leaves both `out_hit` and `out_rd_ff` at 0, so the write is discarded.
- R6: A bank write (`bank_wr` = 1) stores `bank_wdata` AND (VRAM_BYTES / 65536 - 1) in `bank_q`, and sets offset = (stored bank << 16) - 0xA0000. The new offset applies to requests presented from the next cycle onward.
- R7: An enable write (`ext_en_wr` = 1) with `ext_en_val` = 0 sets the offset back to -0xA0000 and leaves `bank_q` unchanged. An enable write with `ext_en_val` = 1 changes neither the offset nor `bank_q`.
- R8: When a bank write and an enable write with `ext_en_val` = 0 occur in the same cycle, the bank number is stored and the offset becomes -0xA0000.
- R9: In map mode 3 every request misses, and a read there sets `out_rd_ff`.
- R10: The outputs of a request presented with `req_valid` = 1 appear exactly one clock later, with `out_valid` = 1. After a cycle with `req_valid` = 0, `out_valid`, `out_hit`, `out_rd_ff` and `out_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_mode | input | 2 | Aperture map mode (0, 1, 2, 3) |
| req_valid | input | 1 | Host access present this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | 32 | Host byte address |
| bank_wr | input | 1 | Bank register write strobe |
| bank_wdata | input | 16 | Bank number to store |
| ext_en_wr | input | 1 | Enable register write strobe |
| ext_en_val | input | 1 | Enable bit value being written |
| bank_q | output | 16 | Stored (masked) bank number |
| out_valid | output | 1 | Registered result present |
| out_hit | output | 1 | Access maps into video memory |
| out_rd_ff | output | 1 | Read must return 0xFF |
| out_addr | output | 32 | Linear video memory byte address |

## Verification
The bench builds the block with VRAM_BYTES set to 1 MiB, which gives 16 banks and a bank mask of 0xF. With that mask, a bank value of 0x23 visibly folds to bank 3, bank 15 reaches the top of memory, and bank 16 folds back to 0. The default 4 MiB build would hide folding behind much larger values. Bank 0 together with a host address below the aperture exercises the modulo-2^32 wrap of the offset addition.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
  localparam int unsigned AW         = 32;
  localparam int unsigned BANK_SHIFT = 16;
  localparam logic [AW-1:0] BASE_A   = 32'h000A_0000;
  localparam logic [AW-1:0] BASE_B   = 32'h000B_0000;
  localparam logic [AW-1:0] OFF_DFLT = 32'h0 - BASE_A;

  typedef enum logic [1:0] {
    MAP_WIDE   = 2'd0,
    MAP_BANKED = 2'd1,
    MAP_HIGH   = 2'd2,
    MAP_NONE   = 2'd3
  } map_mode_e;

  typedef struct packed {
    logic          vld;
    logic          hit;
    logic          rd_ff;
    logic [AW-1:0] addr;
  } xlat_t;
endpackage

// File: rtl/vwm_bank_reg.sv
module vwm_bank_reg
  import vwm_pkg::*;
#(
  parameter int unsigned VRAM_BYTES = 32'h0040_0000,
  parameter int unsigned BANK_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic              ext_en_wr,
  input  logic              ext_en_val,
  output logic [BANK_W-1:0] bank_q,
  output logic [AW-1:0]     off_q
);
  localparam int unsigned      NBANK = VRAM_BYTES >> BANK_SHIFT;
  localparam logic [BANK_W-1:0] MASK = BANK_W'(NBANK - 1);

  logic              dis_wr;
  logic              upd;
  logic [BANK_W-1:0] bank_d;
  logic [AW-1:0]     off_d;

  assign dis_wr = ext_en_wr & ~ext_en_val;
  assign upd    = bank_wr | dis_wr;

  always_comb begin
    bank_d = bank_q;
    off_d  = off_q;
    if (bank_wr) begin
      bank_d = bank_wdata & MASK;
      off_d  = (AW'(bank_d) << BANK_SHIFT) - BASE_A;
    end
    if (dis_wr) begin
      off_d = OFF_DFLT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      off_q  <= OFF_DFLT;
    end else if (upd) begin
      bank_q <= bank_d;
      off_q  <= off_d;
    end
  end
endmodule

// File: rtl/vwm_xlate.sv
module vwm_xlate
  import vwm_pkg::*;
(
  input  logic [1:0]    map_mode,
  input  logic          req_write,
  input  logic [AW-1:0] host_addr,
  input  logic [AW-1:0] off,
  output logic          hit,
  output logic          rd_ff,
  output logic [AW-1:0] lin
);
  map_mode_e mode;
  assign mode = map_mode_e'(map_mode);

  always_comb begin
    hit = 1'b0;
    lin = '0;
    unique case (mode)
      MAP_WIDE: begin
        hit = 1'b1;
        lin = host_addr - BASE_A;
      end
      MAP_BANKED: begin
        if (host_addr < BASE_B) begin
          hit = 1'b1;
          lin = host_addr + off;
        end
      end
      MAP_HIGH: begin
        hit = 1'b1;
        lin = host_addr - BASE_B;
      end
      default: begin
        hit = 1'b0;
      end
    endcase
    rd_ff = ~hit & ~req_write;
  end
endmodule

// File: rtl/vwm_out_reg.sv
module vwm_out_reg
  import vwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          hit,
  input  logic          rd_ff,
  input  logic [AW-1:0] lin,
  output xlat_t         q
);
  xlat_t d;
  logic  en;

  assign en = req_valid | q.vld;

  always_comb begin
    d = '0;
    if (req_valid) begin
      d.vld   = 1'b1;
      d.hit   = hit;
      d.rd_ff = rd_ff;
      d.addr  = lin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/vram_window_map.sv
module vram_window_map
  import vwm_pkg::*;
#(
  parameter int unsigned VRAM_BYTES = 32'h0040_0000,
  parameter int unsigned BANK_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        map_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [31:0]       host_addr,
  input  logic              bank_wr,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic              ext_en_wr,
  input  logic              ext_en_val,
  output logic [BANK_W-1:0] bank_q,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_rd_ff,
  output logic [31:0]       out_addr
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic [AW-1:0] off_q;
  logic          x_hit;
  logic          x_rd_ff;
  logic [AW-1:0] x_lin;
  xlat_t         res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  vwm_bank_reg #(.VRAM_BYTES(VRAM_BYTES), .BANK_W(BANK_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bank_wr    (bank_wr),
    .bank_wdata (bank_wdata),
    .ext_en_wr  (ext_en_wr),
    .ext_en_val (ext_en_val),
    .bank_q     (bank_q),
    .off_q      (off_q)
  );

  vwm_xlate u_xlate (
    .map_mode  (map_mode),
    .req_write (req_write),
    .host_addr (host_addr),
    .off       (off_q),
    .hit       (x_hit),
    .rd_ff     (x_rd_ff),
    .lin       (x_lin)
  );

  vwm_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .hit       (x_hit),
    .rd_ff     (x_rd_ff),
    .lin       (x_lin),
    .q         (res_q)
  );

  assign out_valid = res_q.vld;
  assign out_hit   = res_q.hit;
  assign out_rd_ff = res_q.rd_ff;
  assign out_addr  = res_q.addr;
endmodule

// File: rtl/vwm_checker.sv
module vwm_checker
  import vwm_pkg::*;
#(
  parameter int unsigned VRAM_BYTES = 32'h0040_0000,
  parameter int unsigned BANK_W     = 16
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [1:0]        map_mode,
  input logic              req_valid,
  input logic              bank_wr,
  input logic              ext_en_wr,
  input logic              ext_en_val,
  input logic [BANK_W-1:0] bank_q,
  input logic [AW-1:0]     off_q,
  input logic              out_valid,
  input logic              out_hit,
  input logic              out_rd_ff,
  input logic [31:0]       out_addr
);
  localparam logic [BANK_W-1:0] MASK = BANK_W'((VRAM_BYTES >> BANK_SHIFT) - 1);

  AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bank_q & ~MASK) == '0);                                               // R6
  AST_BANK_OFFSET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bank_wr && !(ext_en_wr && !ext_en_val)) |=>
      off_q == ((AW'(bank_q) << BANK_SHIFT) - BASE_A));                    // R6
  AST_DISABLE_OFFSET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ext_en_wr && !ext_en_val) |=> off_q == OFF_DFLT);                     // R7
  AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && !out_hit) |-> out_addr == '0);                           // R5
  AST_FF_ON_MISS: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_rd_ff |-> (out_valid && !out_hit));                                // R5
  AST_MODE3_MISS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && map_mode == 2'd3) |=> (out_valid && !out_hit));          // R9
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> out_valid);                                              // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> (!out_valid && !out_hit && !out_rd_ff && out_addr == '0)); // R10
endmodule

bind vram_window_map vwm_checker #(.VRAM_BYTES(VRAM_BYTES), .BANK_W(BANK_W)) u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .map_mode   (map_mode),
  .req_valid  (req_valid),
  .bank_wr    (bank_wr),
  .ext_en_wr  (ext_en_wr),
  .ext_en_val (ext_en_val),
  .bank_q     (bank_q),
  .off_q      (off_q),
  .out_valid  (out_valid),
  .out_hit    (out_hit),
  .out_rd_ff  (out_rd_ff),
  .out_addr   (out_addr)
);

// File: tb/sim_vram_window_map.sv
module sim_vram_window_map;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned VRAM_BYTES = 32'h0010_0000;
  localparam int unsigned BANK_W     = 16;
  localparam int unsigned NBANK      = VRAM_BYTES / 65536;
  localparam int unsigned NVEC       = 8;

  // vector: {mode[2], write[1], addr[32], hit[1], ff[1], exp_addr[32]}, bank = 2
  localparam logic [68:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 32'h000A_1234, 1'b1, 1'b0, 32'h0000_1234},  // R2
    {2'd2, 1'b1, 32'h000B_0010, 1'b1, 1'b0, 32'h0000_0010},  // R3
    {2'd1, 1'b0, 32'h000A_0000, 1'b1, 1'b0, 32'h0002_0000},  // R4
    {2'd1, 1'b1, 32'h000A_FFFF, 1'b1, 1'b0, 32'h0002_FFFF},  // R4
    {2'd1, 1'b0, 32'h000B_0000, 1'b0, 1'b1, 32'h0000_0000},  // R5
    {2'd1, 1'b1, 32'h000B_0000, 1'b0, 1'b0, 32'h0000_0000},  // R5
    {2'd1, 1'b0, 32'h000C_0000, 1'b0, 1'b1, 32'h0000_0000},  // R5
    {2'd3, 1'b0, 32'h000A_0000, 1'b0, 1'b1, 32'h0000_0000}   // R9
  };

  logic              clk;
  logic              rst_n;
  logic [1:0]        map_mode;
  logic              req_valid;
  logic              req_write;
  logic [31:0]       host_addr;
  logic              bank_wr;
  logic [BANK_W-1:0] bank_wdata;
  logic              ext_en_wr;
  logic              ext_en_val;
  logic [BANK_W-1:0] bank_q;
  logic              out_valid;
  logic              out_hit;
  logic              out_rd_ff;
  logic [31:0]       out_addr;

  int  checks;
  int  errors;
  bit  done;

  vram_window_map #(.VRAM_BYTES(VRAM_BYTES), .BANK_W(BANK_W)) u0 (
    .clk(clk), .rst_n(rst_n), .map_mode(map_mode), .req_valid(req_valid),
    .req_write(req_write), .host_addr(host_addr), .bank_wr(bank_wr),
    .bank_wdata(bank_wdata), .ext_en_wr(ext_en_wr), .ext_en_val(ext_en_val),
    .bank_q(bank_q), .out_valid(out_valid), .out_hit(out_hit),
    .out_rd_ff(out_rd_ff), .out_addr(out_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] m1_addr(input logic [31:0] a, input int unsigned bank);
    logic [31:0] b;
    b = 32'(bank % NBANK);
    return a + (b * 32'h0001_0000) - 32'h000A_0000;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic hit, input logic ff, input logic [31:0] a);
    chk(req, {29'd0, out_valid, out_hit, out_rd_ff, out_addr}, {29'd0, 1'b1, hit, ff, a});
  endtask

  // starts and ends at a negedge
  task automatic req(input logic [1:0] m, input logic w, input logic [31:0] a);
    map_mode  = m;
    req_write = w;
    host_addr = a;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic bank_write(input logic [BANK_W-1:0] v, input logic dis);
    bank_wr    = 1'b1;
    bank_wdata = v;
    ext_en_wr  = dis;
    ext_en_val = 1'b0;
    @(negedge clk);
    bank_wr   = 1'b0;
    ext_en_wr = 1'b0;
  endtask

  task automatic en_write(input logic v);
    ext_en_wr  = 1'b1;
    ext_en_val = v;
    @(negedge clk);
    ext_en_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; map_mode = 2'd0; req_valid = 1'b0; req_write = 1'b0;
    host_addr = '0; bank_wr = 1'b0; bank_wdata = '0; ext_en_wr = 1'b0; ext_en_val = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {30'd0, out_valid, out_hit, out_rd_ff, out_addr},
        {30'd0, 1'b0, 1'b0, 1'b0, 32'd0});
    chk("R1 bank", 64'(bank_q), 64'd0);
    req(2'd1, 1'b0, 32'h000A_0000);
    chk_out("R1 default offset", 1'b1, 1'b0, 32'd0);

    // R10 idle cycle clears outputs
    @(negedge clk);
    chk("R10 idle", {30'd0, out_valid, out_hit, out_rd_ff, out_addr}, 64'd0);

    // vector table, bank 2
    bank_write(16'd2, 1'b0);
    for (int i = 0; i < NVEC; i++) begin
      req(VEC[i][68:67], VEC[i][66], VEC[i][65:34]);
      chk_out($sformatf("vec%0d R2/R3/R4/R5/R9", i), VEC[i][33], VEC[i][32], VEC[i][31:0]);
    end

    // R6 masking: 0x23 folds to 3
    bank_write(16'h0023, 1'b0);
    chk("R6 mask", 64'(bank_q), 64'd3);
    req(2'd1, 1'b1, 32'h000A_0010);
    chk_out("R6 bank3", 1'b1, 1'b0, m1_addr(32'h000A_0010, 3));

    // R6 top bank
    bank_write(16'd15, 1'b0);
    req(2'd1, 1'b0, 32'h000A_FFFF);
    chk_out("R6 top bank", 1'b1, 1'b0, 32'h000F_FFFF);

    // R6 bank 16 folds to 0
    bank_write(16'd16, 1'b0);
    chk("R6 fold", 64'(bank_q), 64'd0);

    // R4 wrap below aperture with bank 0
    req(2'd1, 1'b0, 32'h0000_0010);
    chk_out("R4 wrap", 1'b1, 1'b0, 32'hFFF6_0010);

    // R6 new offset applies next cycle: same-cycle request sees old bank (0)
    bank_wr = 1'b1; bank_wdata = 16'd5;
    req(2'd1, 1'b0, 32'h000A_0000);
    bank_wr = 1'b0;
    chk_out("R6 old offset same cycle", 1'b1, 1'b0, 32'd0);
    req(2'd1, 1'b0, 32'h000A_0000);
    chk_out("R6 new offset", 1'b1, 1'b0, 32'h0005_0000);

    // R7 enable with bit set: no change
    en_write(1'b1);
    req(2'd1, 1'b0, 32'h000A_0000);
    chk_out("R7 enable set", 1'b1, 1'b0, 32'h0005_0000);

    // R7 disable restores default, bank kept
    en_write(1'b0);
    chk("R7 bank kept", 64'(bank_q), 64'd5);
    req(2'd1, 1'b0, 32'h000A_0010);
    chk_out("R7 default offset", 1'b1, 1'b0, 32'h0000_0010);

    // R8 simultaneous bank and disable
    bank_write(16'd7, 1'b1);
    chk("R8 bank stored", 64'(bank_q), 64'd7);
    req(2'd1, 1'b0, 32'h000A_0020);
    chk_out("R8 disable wins", 1'b1, 1'b0, 32'h0000_0020);

    // R10 back-to-back requests
    map_mode = 2'd0; req_write = 1'b0; host_addr = 32'h000A_0100; req_valid = 1'b1;
    @(negedge clk);
    chk_out("R10 first", 1'b1, 1'b0, 32'h0000_0100);
    map_mode = 2'd2; host_addr = 32'h000B_0200;
    @(negedge clk);
    req_valid = 1'b0;
    chk_out("R10 second", 1'b1, 1'b0, 32'h0000_0200);

    // R1 reset again restores default offset and bank
    bank_write(16'd9, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 bank after reset", 64'(bank_q), 64'd0);
    req(2'd1, 1'b0, 32'h000A_0004);
    chk_out("R1 offset after reset", 1'b1, 1'b0, 32'h0000_0004);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule